// File: doc/BRIEF.md
# Asynchronous SRAM Device Model

A clocked, synthesizable stand-in for a 128K x 8 asynchronous static RAM, meant to sit in a testbench or an emulation build as the memory device a controller talks to. Two chip selects (one active-low, one active-high), an active-low write strobe and an active-low output enable are decoded into four modes: standby, internal read (selected but outputs off), read and write. The data bus is split into an input value, an output value and an output-enable, which together describe a three-state bus.

Every timing figure is a count of model-clock ticks. All inputs are sampled on each rising edge. A read restarts whenever the address changes while the device is selected: the outputs are blanked at once and come back only after the full access delay. Turn-off after deselection, after output-enable release or after a write begins takes its own delay, and the last word is held on the bus during that time. A write is committed when it ends, which is the first of the three strobes to leave the write condition. A one-cycle flag reports a write pulse that is too short or data that did not settle early enough. The stored depth is a parameter, so a simulation can use a small array. Address bits above that depth are ignored.

Top module: `async_sram_model`

## Requirements
- R1: After reset `dq_oe_o` and `timing_err_o` are 0.
- R2: While the device is deselected (`ce1_n_i`=1 or `ce2_i`=0) and not already driving, `dq_oe_o` stays 0 whatever `we_n_i` and `oe_n_i` are, and no word is stored.
- R3: While selected with `we_n_i`=1 and `oe_n_i`=1 (internal read), `dq_oe_o` stays 0 however long the state lasts.
- R4: In read mode (selected, `we_n_i`=1, `oe_n_i`=0) `dq_oe_o` goes to 1 with `dq_o` equal to the stored word at the first rising edge at which at least T_ACC edges have passed since the edge that saw the last selection or address change, and at least T_OE edges have passed since the edge that first saw read mode. Before that edge `dq_oe_o` is 0.
- R5: An address change (in the low AW bits) seen at an edge while in read mode clears `dq_oe_o` at that same edge. The new word then appears T_ACC edges later.
- R6: Address bits at position AW and above have no effect: changing them neither restarts a read nor selects a different word.
- R7: A write condition (selected and `we_n_i`=0) ends at the first edge that no longer sees it, whether `we_n_i` rose, `ce1_n_i` rose or `ce2_i` fell. At that edge the array stores `dq_i` and the low address bits as sampled at the last edge that still saw the write condition.
- R8: When read mode is left while `dq_oe_o`=1, `dq_oe_o` stays 1 with `dq_o` unchanged for exactly T_HZ_CE edges if the cause is deselection, T_HZ_WE edges if the cause is `we_n_i`=0, and T_HZ_OE edges if the cause is `oe_n_i`=1. It then goes to 0.
- R9: At the edge where a write ends, `timing_err_o` is set for one cycle if fewer than T_WP consecutive edges saw the write condition, or if `dq_i` was constant for fewer than T_DS of the last write edges. The write is still committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; every delay is counted in its rising edges |
| rst_n | input | 1 | Synchronous active-low reset of the control state (not the array) |
| addr_i | input | ADDR_W | Word address; only the low AW bits are decoded |
| ce1_n_i | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dq_i | input | DATA_W | Value present on the data bus from the controller |
| dq_o | output | DATA_W | Value the device drives onto the data bus |
| dq_oe_o | output | 1 | Output driver enable; 0 means the bus is high-Z from the device |
| timing_err_o | output | 1 | One-cycle flag for a write pulse or data setup violation |

## Verification
Each result lands a fixed number of edges after the edge that first sees a stimulus. The data comes out T_ACC (or T_OE) edges later, the bus turns off T_HZ_* edges later, the blanking on an address change happens at the edge that sees the change, and the error flag is set at the edge that sees the write end. The bench changes inputs on falling edges and samples on falling edges. A stimulus driven before falling edge N is therefore seen at rising edge N+1, and a result due D edges later is read at the falling edge D+1 after the drive point. Each delay is checked on both sides: one sample is taken one falling edge before the result is due and must still show the old value, and one is taken at the due edge and must show the new value. Pulse-width and setup limits are exercised both at the limit and one edge short of it.

// File: rtl/sram_model_pkg.sv
// Shared types for the asynchronous SRAM model.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_model_pkg;

    // Device mode decoded from the two selects, write strobe and output enable.
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,  // deselected
        MODE_SENSE = 2'd1,  // selected, outputs off
        MODE_DRIVE = 2'd2,  // selected, reading onto the bus
        MODE_STORE = 2'd3   // selected, write strobe active
    } mode_e;

    // Larger of two counts, used to size counters.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_mode_decode.sv
// Decodes the pin levels into one device mode.
// Assumes: pins are already synchronous to the model clock; purely combinational.
module sram_mode_decode
    import sram_model_pkg::*;
(
    input  logic  ce1_n,
    input  logic  ce2,
    input  logic  we_n,
    input  logic  oe_n,
    output mode_e mode
);

    // Select decode first; the write strobe outranks the output enable.
    always_comb begin
        if (ce1_n || !ce2) begin
            mode = MODE_IDLE;
        end else if (!we_n) begin
            mode = MODE_STORE;
        end else if (!oe_n) begin
            mode = MODE_DRIVE;
        end else begin
            mode = MODE_SENSE;
        end
    end

endmodule

// File: rtl/sram_store.sv
// Storage array: one synchronous write port, one combinational read port.
// Assumes: contents are not reset; DEPTH = 2**AW words.
module sram_store #(
    parameter int AW     = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit a finished write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Present the addressed word to the read path.
    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/sram_read_path.sv
// Read timing: access age, enable age, output drive and delayed turn-off.
// Assumes: all delays are at least 1; addr_evt is set at an edge that sees a
// fresh selection or a change of the decoded address bits.
module sram_read_path
    import sram_model_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int T_ACC   = 14,
    parameter int T_OE    = 5,
    parameter int T_HZ_CE = 3,
    parameter int T_HZ_OE = 3,
    parameter int T_HZ_WE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              addr_evt,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    localparam int unsigned T_HZ_MAX = max2(max2(T_HZ_CE, T_HZ_OE), T_HZ_WE);
    localparam int unsigned T_TOP    = max2(max2(T_ACC, T_OE), T_HZ_MAX);
    localparam int          CW       = $clog2(T_TOP + 1) + 1;

    logic [CW-1:0] acc_age, acc_next;
    logic [CW-1:0] en_age, en_next;
    logic [CW-1:0] off_cnt, off_load;
    logic          rd_now, rd_prev, ready, off_run;

    assign rd_now = (mode == MODE_DRIVE);

    // Next ages: ticks since the access event and since read mode began, saturating.
    always_comb begin
        if (mode == MODE_IDLE || addr_evt) begin
            acc_next = '0;
        end else if (acc_age >= CW'(T_ACC)) begin
            acc_next = acc_age;
        end else begin
            acc_next = acc_age + CW'(1);
        end

        if (!rd_now || !rd_prev) begin
            en_next = '0;
        end else if (en_age >= CW'(T_OE)) begin
            en_next = en_age;
        end else begin
            en_next = en_age + CW'(1);
        end
    end

    assign ready = rd_now && (acc_next >= CW'(T_ACC)) && (en_next >= CW'(T_OE));

    // Turn-off delay chosen by the reason read mode was left.
    always_comb begin
        case (mode)
            MODE_IDLE:  off_load = CW'(T_HZ_CE - 1);
            MODE_STORE: off_load = CW'(T_HZ_WE - 1);
            default:    off_load = CW'(T_HZ_OE - 1);
        endcase
    end

    // Age counters and the previous read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_age <= '0;
            en_age  <= '0;
            rd_prev <= 1'b0;
        end else begin
            acc_age <= acc_next;
            en_age  <= en_next;
            rd_prev <= rd_now;
        end
    end

    // Output driver: drive when ready, blank on restart, hold then release on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe   <= 1'b0;
            dq_o    <= '0;
            off_run <= 1'b0;
            off_cnt <= '0;
        end else if (rd_now) begin
            dq_oe   <= ready;
            off_run <= 1'b0;
            if (ready) begin
                dq_o <= word;
            end
        end else if (dq_oe && !off_run) begin
            off_run <= 1'b1;
            off_cnt <= off_load;
        end else if (off_run) begin
            if (off_cnt == '0) begin
                dq_oe   <= 1'b0;
                off_run <= 1'b0;
            end else begin
                off_cnt <= off_cnt - CW'(1);
            end
        end
    end

endmodule

// File: rtl/sram_write_ctl.sv
// Write tracking: latches address and data each write edge, commits at the
// end of the write, and checks pulse width and data setup.
// Assumes: T_WP and T_DS are at least 1.
module sram_write_ctl
    import sram_model_pkg::*;
#(
    parameter int AW     = 10,
    parameter int DATA_W = 8,
    parameter int T_WP   = 7,
    parameter int T_DS   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [AW-1:0]     addr_lo,
    input  logic [DATA_W-1:0] dq_i,
    output logic              commit,
    output logic [AW-1:0]     commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              timing_err
);

    localparam int CW = $clog2(max2(T_WP, T_DS) + 1) + 1;

    logic          wr_now, wr_prev;
    logic [CW-1:0] pulse_cnt, stable_cnt;

    assign wr_now = (mode == MODE_STORE);
    assign commit = wr_prev && !wr_now;

    // Track the write pulse, its last address/data, and its pulse/stability counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev     <= 1'b0;
            commit_addr <= '0;
            commit_data <= '0;
            pulse_cnt   <= '0;
            stable_cnt  <= '0;
        end else begin
            wr_prev <= wr_now;
            if (wr_now) begin
                commit_addr <= addr_lo;
                commit_data <= dq_i;
                if (!wr_prev) begin
                    pulse_cnt <= CW'(1);
                end else if (pulse_cnt < CW'(T_WP)) begin
                    pulse_cnt <= pulse_cnt + CW'(1);
                end
                if (!wr_prev || dq_i != commit_data) begin
                    stable_cnt <= CW'(1);
                end else if (stable_cnt < CW'(T_DS)) begin
                    stable_cnt <= stable_cnt + CW'(1);
                end
            end
        end
    end

    // Flag a short pulse or late data at the edge that ends the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_err <= 1'b0;
        end else begin
            timing_err <= commit &&
                          ((pulse_cnt < CW'(T_WP)) || (stable_cnt < CW'(T_DS)));
        end
    end

endmodule

// File: rtl/async_sram_model.sv
// Top of the asynchronous SRAM model: decode, address-change detection,
// storage, read timing and write control.
// Assumes: inputs are sampled on each rising clk edge; delays are in ticks
// and at least 1; AW does not exceed ADDR_W.
module async_sram_model
    import sram_model_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int AW      = 10,
    parameter int DATA_W  = 8,
    parameter int T_ACC   = 14,
    parameter int T_OE    = 5,
    parameter int T_HZ_CE = 3,
    parameter int T_HZ_OE = 3,
    parameter int T_HZ_WE = 4,
    parameter int T_WP    = 7,
    parameter int T_DS    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce1_n_i,
    input  logic              ce2_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              timing_err_o
);

    mode_e             mode;
    logic [AW-1:0]     addr_lo, prev_addr;
    logic              prev_sel, sel_now, addr_evt;
    logic              commit;
    logic [AW-1:0]     commit_addr;
    logic [DATA_W-1:0] commit_data, rd_word;

    // Keep only the decoded address bits; the rest are deliberately dropped.
    generate
        if (AW < ADDR_W) begin : g_trim
            logic unused_hi;
            assign unused_hi = ^addr_i[ADDR_W-1:AW];
        end
        if (AW > ADDR_W) begin : g_bad_aw
            $error("AW must not exceed ADDR_W");
        end
    endgenerate
    assign addr_lo = addr_i[AW-1:0];

    sram_mode_decode u_decode (
        .ce1_n (ce1_n_i),
        .ce2   (ce2_i),
        .we_n  (we_n_i),
        .oe_n  (oe_n_i),
        .mode  (mode)
    );

    assign sel_now  = (mode != MODE_IDLE);
    assign addr_evt = sel_now && (!prev_sel || addr_lo != prev_addr);

    // Remember the last selection and decoded address for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel  <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_sel  <= sel_now;
            prev_addr <= addr_lo;
        end
    end

    sram_store #(
        .AW     (AW),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (commit_addr),
        .wr_data (commit_data),
        .rd_addr (addr_lo),
        .rd_data (rd_word)
    );

    sram_read_path #(
        .DATA_W  (DATA_W),
        .T_ACC   (T_ACC),
        .T_OE    (T_OE),
        .T_HZ_CE (T_HZ_CE),
        .T_HZ_OE (T_HZ_OE),
        .T_HZ_WE (T_HZ_WE)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .addr_evt (addr_evt),
        .word     (rd_word),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe_o)
    );

    sram_write_ctl #(
        .AW     (AW),
        .DATA_W (DATA_W),
        .T_WP   (T_WP),
        .T_DS   (T_DS)
    ) u_write (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .addr_lo     (addr_lo),
        .dq_i        (dq_i),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .timing_err  (timing_err_o)
    );

endmodule

// File: rtl/sram_model_checks.sv
// Port-level properties of the SRAM model, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module sram_model_checks #(
    parameter int ADDR_W = 17,
    parameter int AW     = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ce1_n_i,
    input logic              ce2_i,
    input logic              we_n_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o,
    input logic              timing_err_o
);

    logic selected, reading, writing;
    assign selected = !ce1_n_i && ce2_i;
    assign reading  = selected && we_n_i && !oe_n_i;
    assign writing  = selected && !we_n_i;

    // R2: deselected and quiet stays quiet
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!selected && !dq_oe_o) |=> !dq_oe_o);

    // R3: internal read never turns the bus on
    a_r3_internal_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && we_n_i && oe_n_i && !dq_oe_o) |=> !dq_oe_o);

    // R4: the bus only turns on from read mode
    a_r4_drive_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe_o) |-> $past(reading));

    // R5: an address change in read mode blanks the bus
    a_r5_addr_change_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && addr_i[AW-1:0] != $past(addr_i[AW-1:0])) |=> !dq_oe_o);

    // R8: leaving read mode keeps the last word on the bus for at least one edge
    a_r8_turn_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o && !reading && $past(reading)) |=> (dq_oe_o && $stable(dq_o)));

    // R9: the error flag lasts one cycle
    a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err_o |=> !timing_err_o);

    // R9: the error flag only follows a write
    a_r9_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timing_err_o) |-> $past(writing, 2));

endmodule

bind async_sram_model sram_model_checks #(
    .ADDR_W (ADDR_W),
    .AW     (AW),
    .DATA_W (DATA_W)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .ce1_n_i      (ce1_n_i),
    .ce2_i        (ce2_i),
    .we_n_i       (we_n_i),
    .oe_n_i       (oe_n_i),
    .dq_o         (dq_o),
    .dq_oe_o      (dq_oe_o),
    .timing_err_o (timing_err_o)
);

// File: tb/tb_async_sram_model.sv
`timescale 1ns/1ps
module tb_async_sram_model;

    localparam int ADDR_W  = 17;
    localparam int AW      = 10;
    localparam int DATA_W  = 8;
    localparam int T_ACC   = 14;
    localparam int T_OE    = 5;
    localparam int T_HZ_CE = 3;
    localparam int T_HZ_OE = 3;
    localparam int T_HZ_WE = 4;
    localparam int T_WP    = 7;
    localparam int T_DS    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce1_n = 1'b1, ce2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dq_o;
    logic              dq_oe, terr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    async_sram_model #(
        .ADDR_W (ADDR_W), .AW (AW), .DATA_W (DATA_W),
        .T_ACC (T_ACC), .T_OE (T_OE), .T_HZ_CE (T_HZ_CE), .T_HZ_OE (T_HZ_OE),
        .T_HZ_WE (T_HZ_WE), .T_WP (T_WP), .T_DS (T_DS)
    ) dut (
        .clk (clk), .rst_n (rst_n), .addr_i (addr),
        .ce1_n_i (ce1_n), .ce2_i (ce2), .we_n_i (we_n), .oe_n_i (oe_n),
        .dq_i (din), .dq_o (dq_o), .dq_oe_o (dq_oe), .timing_err_o (terr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        tick(6);
    endtask

    // Write with a given number of strobe edges; ends by raising we_n.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int edges);
        addr = a; din = d; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b1; we_n = 1'b0;
        tick(edges);
        we_n = 1'b1;
        tick(1);
    endtask

    // Open a read from idle and wait until the word is due.
    task automatic open_read(input logic [ADDR_W-1:0] a);
        go_idle();
        addr = a; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        tick(T_ACC + 1);
    endtask

    task automatic read_expect(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        open_read(a);
        chk(req, {31'd0, dq_oe}, 32'd1);
        chk(req, {24'd0, dq_o}, {24'd0, d});
        go_idle();
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", {31'd0, dq_oe}, 32'd0);
        chk("R1 err after reset", {31'd0, terr}, 32'd0);
    endtask

    task automatic t_basic_read();
        do_write(17'd5, 8'hA5, 8);
        chk("R9 no err on good write", {31'd0, terr}, 32'd0);
        do_write(17'd6, 8'h3C, 8);
        go_idle();
        addr = 17'd5; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0;
        tick(T_ACC);
        chk("R4 not yet driven", {31'd0, dq_oe}, 32'd0);
        tick(1);
        chk("R4 driven on time", {31'd0, dq_oe}, 32'd1);
        chk("R4 word", {24'd0, dq_o}, 32'hA5);
    endtask

    task automatic t_addr_change();
        addr = 17'd6;
        tick(1);
        chk("R5 blank at change", {31'd0, dq_oe}, 32'd0);
        tick(T_ACC - 1);
        chk("R5 still blank", {31'd0, dq_oe}, 32'd0);
        tick(1);
        chk("R5 new word drive", {31'd0, dq_oe}, 32'd1);
        chk("R5 new word", {24'd0, dq_o}, 32'h3C);
    endtask

    task automatic t_upper_bits();
        addr = 17'd6 | (17'd1 << 16);
        tick(1);
        chk("R6 no restart", {31'd0, dq_oe}, 32'd1);
        tick(T_ACC + 2);
        chk("R6 word kept", {24'd0, dq_o}, 32'h3C);
        go_idle();
        do_write((17'd1 << 12) | 17'd7, 8'h77, 8);
        read_expect("R6 alias", 17'd7, 8'h77);
    endtask

    task automatic t_standby();
        addr = 17'd5; din = 8'hFF; we_n = 1'b0; oe_n = 1'b0;
        ce1_n = 1'b1; ce2 = 1'b1;
        tick(T_ACC + 6);
        chk("R2 ce1 high quiet", {31'd0, dq_oe}, 32'd0);
        ce1_n = 1'b0; ce2 = 1'b0;
        tick(T_ACC + 6);
        chk("R2 ce2 low quiet", {31'd0, dq_oe}, 32'd0);
        go_idle();
        read_expect("R2 no store in standby", 17'd5, 8'hA5);
    endtask

    task automatic t_internal_read();
        addr = 17'd5; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(T_ACC + 6);
        chk("R3 internal read quiet", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0;
        tick(T_OE);
        chk("R4 oe delay not met", {31'd0, dq_oe}, 32'd0);
        tick(1);
        chk("R4 oe delay met", {31'd0, dq_oe}, 32'd1);
        go_idle();
    endtask

    task automatic t_turn_off();
        open_read(17'd5);
        oe_n = 1'b1;
        tick(T_HZ_OE);
        chk("R8 oe hold", {31'd0, dq_oe}, 32'd1);
        chk("R8 oe hold word", {24'd0, dq_o}, 32'hA5);
        tick(1);
        chk("R8 oe off", {31'd0, dq_oe}, 32'd0);
        open_read(17'd5);
        ce1_n = 1'b1;
        tick(T_HZ_CE);
        chk("R8 ce hold", {31'd0, dq_oe}, 32'd1);
        tick(1);
        chk("R8 ce off", {31'd0, dq_oe}, 32'd0);
        open_read(17'd5);
        din = 8'hA5; we_n = 1'b0;
        tick(T_HZ_WE);
        chk("R8 we hold", {31'd0, dq_oe}, 32'd1);
        tick(1);
        chk("R8 we off", {31'd0, dq_oe}, 32'd0);
        tick(4);
        we_n = 1'b1;
        tick(1);
        chk("R9 long pulse no err", {31'd0, terr}, 32'd0);
        go_idle();
    endtask

    task automatic t_write_end();
        addr = 17'd9; din = 8'h91; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0;
        tick(8);
        ce1_n = 1'b1;
        tick(1);
        go_idle();
        read_expect("R7 end by ce1", 17'd9, 8'h91);
        addr = 17'd10; din = 8'hA2; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0;
        tick(8);
        ce2 = 1'b0;
        tick(1);
        go_idle();
        read_expect("R7 end by ce2", 17'd10, 8'hA2);
        addr = 17'd11; din = 8'hB3; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0;
        tick(8);
        we_n = 1'b1; din = 8'h00;
        tick(1);
        go_idle();
        read_expect("R7 last sampled data", 17'd11, 8'hB3);
    endtask

    task automatic t_pulse_width();
        do_write(17'd12, 8'h12, T_WP - 1);
        chk("R9 short pulse flag", {31'd0, terr}, 32'd1);
        tick(1);
        chk("R9 flag one cycle", {31'd0, terr}, 32'd0);
        go_idle();
        read_expect("R9 short write kept", 17'd12, 8'h12);
        do_write(17'd12, 8'h21, T_WP);
        chk("R9 pulse at limit", {31'd0, terr}, 32'd0);
        go_idle();
    endtask

    task automatic t_setup();
        addr = 17'd13; din = 8'h40; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0;
        tick(9);
        din = 8'h41;
        tick(1);
        we_n = 1'b1;
        tick(1);
        chk("R9 setup flag", {31'd0, terr}, 32'd1);
        go_idle();
        read_expect("R9 late data stored", 17'd13, 8'h41);
        addr = 17'd14; din = 8'h50; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0;
        tick(5);
        din = 8'h51;
        tick(T_DS);
        we_n = 1'b1;
        tick(1);
        chk("R9 setup at limit", {31'd0, terr}, 32'd0);
        go_idle();
        read_expect("R7 stored at limit", 17'd14, 8'h51);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_basic_read();
        t_addr_change();
        t_upper_bits();
        t_standby();
        t_internal_read();
        t_turn_off();
        t_write_end();
        t_pulse_width();
        t_setup();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule